// File: doc/BRIEF.md
# Host-Paced Remote Buffer Transfer Engine

This block lets a host move data into or out of a local packet buffer through a single data port. Each host access of that port moves one byte, or two bytes in word mode, between the port and the buffer location named by a live address pointer. The pointer then steps forward and a remaining-byte counter steps down. The host sets up a transfer through byte-wide registers: a start address, a byte count and a word-mode switch. It then writes a command code into a three-bit field of the command register to begin a read run, begin a write run, or stop.

While a run is in progress, the host can read back the live address and the remaining count at any time. This lets it confirm the engine's position before it turns the direction around. When the count runs out, the run ends and a sticky completion flag is raised. The flag is visible both on an output pin and as bit 6 of the status register, and the host clears it by writing a one to that bit. The buffer memory sits outside the block and is reached through an address bus, a two-byte read bus and a two-lane write bus with per-lane write enables.

Register offsets on `regAddr`: 0 command (code in bits 5:3), 1 start low, 2 start high, 3 count low, 4 count high, 5 live address low, 6 live address high, 7 status (completion at bit 6), 8 configuration (word mode at bit 0), 9 remaining low, 10 remaining high.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the block is idle, `rdmaDone` is 0, `memWe` is 0, and the live address, remaining count and status registers all read 0.
- R2: Writing code 1 (read) or code 2 (write) into command bits 5:3 copies the start address into the live address and the byte count into the remaining count. The result is visible at offsets 5/6 and 9/10 on the cycle after the write.
- R3: In a read run, each data-port read returns the buffer byte at the live address on `portRdData[7:0]` with the upper byte 0. After that access the live address rises by one and the remaining count falls by one.
- R4: In a write run, each data-port write drives `portWrData[7:0]` to the live address with `memWe` = 01 and then advances as in R3. `memWe` is never nonzero outside an accepted write-run access.
- R5: The access that brings the remaining count to zero ends the run and sets the completion flag (`rdmaDone` = 1, status bit 6 reads 1) on the following cycle.
- R6: The completion flag stays set until the status register is written with bit 6 = 1. Writing status with bit 6 = 0 leaves it set.
- R7: Data-port accesses while idle, after the count has run out, or in the direction opposite to the active run neither write the buffer nor move the live address.
- R8: Code 4 (abort) ends any run at once without setting the completion flag, and the live address keeps its value.
- R9: With configuration bit 0 set, each access carries two bytes: the byte at the live address on bits 7:0 and the next byte on bits 15:8, with `memWe` = 11 on writes. The address advances by two, and a remaining count of one is taken down to zero.
- R10: Starting a read or write run with a byte count of zero sets the completion flag at once and moves nothing.
- R11: Command codes 0, 3, 5, 6 and 7 leave an active run, its address and its count untouched.
- R12: Writing the start or count registers during a run does not alter the live address or remaining count of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` |
| portRd | input | 1 | Data-port read access (one cycle per access) |
| portWr | input | 1 | Data-port write access (one cycle per access) |
| portWrData | input | 16 | Data-port write data |
| portRdData | output | 16 | Data-port read data |
| memAddr | output | 16 | Buffer address (live address) |
| memRdData | input | 16 | Buffer bytes at memAddr (7:0) and memAddr+1 (15:8) |
| memWrData | output | 16 | Buffer write data |
| memWe | output | 2 | Per-lane buffer write enables |
| rdmaDone | output | 1 | Sticky completion flag |

## Verification
The hardest case to reach is a word-mode run whose count is odd. The last access finds only one byte left, yet it still moves two lanes, and the count must then settle at zero instead of wrapping. The stimulus programs a count of three in word mode, issues two port writes and reads the remaining-count register between them. A related case is a run stopped partway by abort, or left running through the no-op codes, and the stimulus checks the live address after each of these.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int BYTE_W    = 8;
  localparam int LANES     = 2;
  localparam int PORT_W    = LANES * BYTE_W;
  localparam int ADDR_W    = 16;
  localparam int CNT_W     = 16;
  localparam int REG_AW    = 4;
  localparam int FIELD_LSB = 3;
  localparam int FIELD_W   = 3;
  localparam int DONE_BIT  = 6;
  localparam int WORD_BIT  = 0;

  localparam logic [FIELD_W-1:0] CODE_READ  = 3'd1;
  localparam logic [FIELD_W-1:0] CODE_WRITE = 3'd2;
  localparam logic [FIELD_W-1:0] CODE_ABORT = 3'd4;

  localparam logic [REG_AW-1:0] RA_CMD    = 4'd0;
  localparam logic [REG_AW-1:0] RA_STRT_L = 4'd1;
  localparam logic [REG_AW-1:0] RA_STRT_H = 4'd2;
  localparam logic [REG_AW-1:0] RA_CNT_L  = 4'd3;
  localparam logic [REG_AW-1:0] RA_CNT_H  = 4'd4;
  localparam logic [REG_AW-1:0] RA_CUR_L  = 4'd5;
  localparam logic [REG_AW-1:0] RA_CUR_H  = 4'd6;
  localparam logic [REG_AW-1:0] RA_STAT   = 4'd7;
  localparam logic [REG_AW-1:0] RA_CFG    = 4'd8;
  localparam logic [REG_AW-1:0] RA_REM_L  = 4'd9;
  localparam logic [REG_AW-1:0] RA_REM_H  = 4'd10;

  typedef enum logic [1:0] {RUN_IDLE, RUN_READ, RUN_WRITE} runModeT;

  typedef struct packed {
    logic loadRun;
    logic step;
  } ctrlStbT;
endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [FIELD_W-1:0] wrField,
  input  logic               wrDoneBit,
  input  logic               portRd,
  input  logic               portWr,
  input  logic               lastStep,
  input  logic               cntIsZero,
  output ctrlStbT            stb,
  output runModeT            runMode,
  output logic               doneFlag,
  output logic [FIELD_W-1:0] cmdField
);
  logic    cmdWr, startRead, startWrite, abortCmd, setDone, clrDone;
  runModeT runNext;

  assign cmdWr      = regWr && (regAddr == RA_CMD);
  assign startRead  = cmdWr && (wrField == CODE_READ);
  assign startWrite = cmdWr && (wrField == CODE_WRITE);
  assign abortCmd   = cmdWr && (wrField == CODE_ABORT);

  // A command write in the same cycle takes precedence over a port access.
  assign stb.loadRun = startRead || startWrite;
  assign stb.step    = !cmdWr &&
                       (((runMode == RUN_READ)  && portRd) ||
                        ((runMode == RUN_WRITE) && portWr));

  assign setDone = (stb.loadRun && cntIsZero) || (stb.step && lastStep);
  assign clrDone = regWr && (regAddr == RA_STAT) && wrDoneBit;

  always_comb begin
    runNext = runMode;
    if (stb.loadRun) begin
      if (cntIsZero)       runNext = RUN_IDLE;
      else if (startRead)  runNext = RUN_READ;
      else                 runNext = RUN_WRITE;
    end else if (abortCmd) begin
      runNext = RUN_IDLE;
    end else if (stb.step && lastStep) begin
      runNext = RUN_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runMode  <= RUN_IDLE;
      doneFlag <= 1'b0;
      cmdField <= '0;
    end else begin
      runMode <= runNext;
      if (cmdWr) cmdField <= wrField;
      if (setDone)      doneFlag <= 1'b1;
      else if (clrDone) doneFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/rdma_dp.sv
module rdma_dp
  import rdma_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [BYTE_W-1:0]  regWrData,
  input  ctrlStbT            stb,
  input  runModeT            runMode,
  input  logic               doneFlag,
  input  logic [FIELD_W-1:0] cmdField,
  input  logic [PORT_W-1:0]  portWrData,
  input  logic [PORT_W-1:0]  memRdData,
  output logic [PORT_W-1:0]  portRdData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [PORT_W-1:0]  memWrData,
  output logic [LANES-1:0]   memWe,
  output logic [BYTE_W-1:0]  regRdData,
  output logic               lastStep,
  output logic               cntIsZero,
  output logic               wordMode
);
  logic [ADDR_W-1:0] startAddr, curAddr;
  logic [CNT_W-1:0]  byteCount, remCount, stepSize;
  logic              writeStep;

  assign stepSize  = wordMode ? CNT_W'(2) : CNT_W'(1);
  assign lastStep  = remCount <= stepSize;
  assign cntIsZero = (byteCount == '0);
  assign writeStep = stb.step && (runMode == RUN_WRITE);
  assign memAddr   = curAddr;
  assign memWrData = portWrData;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k == 0) begin : g_base
      assign memWe[k] = writeStep;
      assign portRdData[k*BYTE_W +: BYTE_W] = memRdData[k*BYTE_W +: BYTE_W];
    end else begin : g_wide
      assign memWe[k] = writeStep && wordMode;
      assign portRdData[k*BYTE_W +: BYTE_W] =
        wordMode ? memRdData[k*BYTE_W +: BYTE_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startAddr <= '0;
      byteCount <= '0;
      curAddr   <= '0;
      remCount  <= '0;
      wordMode  <= 1'b0;
    end else begin
      if (regWr) begin
        case (regAddr)
          RA_STRT_L: startAddr[BYTE_W-1:0]      <= regWrData;
          RA_STRT_H: startAddr[ADDR_W-1:BYTE_W] <= regWrData;
          RA_CNT_L:  byteCount[BYTE_W-1:0]      <= regWrData;
          RA_CNT_H:  byteCount[CNT_W-1:BYTE_W]  <= regWrData;
          RA_CFG:    wordMode                   <= regWrData[WORD_BIT];
          default: ;
        endcase
      end
      if (stb.loadRun) begin
        curAddr  <= startAddr;
        remCount <= byteCount;
      end else if (stb.step) begin
        curAddr  <= curAddr + ADDR_W'(stepSize);
        remCount <= lastStep ? '0 : remCount - stepSize;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      RA_CMD:    regRdData[FIELD_LSB +: FIELD_W] = cmdField;
      RA_STRT_L: regRdData = startAddr[BYTE_W-1:0];
      RA_STRT_H: regRdData = startAddr[ADDR_W-1:BYTE_W];
      RA_CNT_L:  regRdData = byteCount[BYTE_W-1:0];
      RA_CNT_H:  regRdData = byteCount[CNT_W-1:BYTE_W];
      RA_CUR_L:  regRdData = curAddr[BYTE_W-1:0];
      RA_CUR_H:  regRdData = curAddr[ADDR_W-1:BYTE_W];
      RA_STAT:   regRdData[DONE_BIT] = doneFlag;
      RA_CFG:    regRdData[WORD_BIT] = wordMode;
      RA_REM_L:  regRdData = remCount[BYTE_W-1:0];
      RA_REM_H:  regRdData = remCount[CNT_W-1:BYTE_W];
      default: ;
    endcase
  end
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              portRd,
  input  logic              portWr,
  input  logic [PORT_W-1:0] portWrData,
  output logic [PORT_W-1:0] portRdData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [PORT_W-1:0] memRdData,
  output logic [PORT_W-1:0] memWrData,
  output logic [LANES-1:0]  memWe,
  output logic              rdmaDone
);
  ctrlStbT            stb;
  runModeT            runMode;
  logic               doneFlag, lastStep, cntIsZero, wordMode;
  logic               stepStb, loadStb;
  logic [FIELD_W-1:0] cmdField;

  assign rdmaDone = doneFlag;
  assign stepStb  = stb.step;
  assign loadStb  = stb.loadRun;

  rdma_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .wrField   (regWrData[FIELD_LSB +: FIELD_W]),
    .wrDoneBit (regWrData[DONE_BIT]),
    .portRd    (portRd),
    .portWr    (portWr),
    .lastStep  (lastStep),
    .cntIsZero (cntIsZero),
    .stb       (stb),
    .runMode   (runMode),
    .doneFlag  (doneFlag),
    .cmdField  (cmdField)
  );

  rdma_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .stb        (stb),
    .runMode    (runMode),
    .doneFlag   (doneFlag),
    .cmdField   (cmdField),
    .portWrData (portWrData),
    .memRdData  (memRdData),
    .portRdData (portRdData),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .memWe      (memWe),
    .regRdData  (regRdData),
    .lastStep   (lastStep),
    .cntIsZero  (cntIsZero),
    .wordMode   (wordMode)
  );
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk
  import rdma_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               statClr,
  input logic               abortWr,
  input logic               portWr,
  input logic [ADDR_W-1:0]  memAddr,
  input logic [LANES-1:0]   memWe,
  input logic               rdmaDone,
  input runModeT            runMode,
  input logic               stepStb,
  input logic               loadStb,
  input logic               wordMode
);
  AST_WE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memWe != '0) |-> (runMode == RUN_WRITE && portWr)); // R4

  AST_WE_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (memWe != '0) |-> (memWe == (wordMode ? 2'b11 : 2'b01))); // R9

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    stepStb |=> (memAddr == ADDR_W'($past(memAddr) + ($past(wordMode) ? 2 : 1)))); // R3

  AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (runMode == RUN_IDLE && !loadStb) |=> $stable(memAddr)); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rdmaDone && !statClr) |=> rdmaDone); // R6

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdmaDone) |-> (runMode == RUN_IDLE)); // R5

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    abortWr |=> (runMode == RUN_IDLE)); // R8
endmodule

bind rdma_port_engine rdma_port_engine_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .statClr  (regWr && regAddr == rdma_pkg::RA_STAT && regWrData[rdma_pkg::DONE_BIT]),
  .abortWr  (regWr && regAddr == rdma_pkg::RA_CMD &&
             regWrData[rdma_pkg::FIELD_LSB +: rdma_pkg::FIELD_W] == rdma_pkg::CODE_ABORT),
  .portWr   (portWr),
  .memAddr  (memAddr),
  .memWe    (memWe),
  .rdmaDone (rdmaDone),
  .runMode  (runMode),
  .stepStb  (stepStb),
  .loadStb  (loadStb),
  .wordMode (wordMode)
);

// File: tb/rdma_port_engine_tb.sv
`timescale 1ns/1ps
module rdma_port_engine_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        portRd = 1'b0;
  logic        portWr = 1'b0;
  logic [15:0] portWrData = '0;
  logic [15:0] portRdData;
  logic [15:0] memAddr;
  logic [15:0] memRdData;
  logic [15:0] memWrData;
  logic [1:0]  memWe;
  logic        rdmaDone;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  logic [15:0] expVal[$];
  string       expReq[$];
  logic [7:0]  mem [0:255];

  always #2.5 clk = ~clk;

  rdma_port_engine u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .portRd(portRd),
    .portWr(portWr), .portWrData(portWrData), .portRdData(portRdData),
    .memAddr(memAddr), .memRdData(memRdData), .memWrData(memWrData),
    .memWe(memWe), .rdmaDone(rdmaDone)
  );

  function automatic logic [7:0] refVal(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = refVal(i);

  assign memRdData = {mem[8'(memAddr[7:0] + 8'd1)], mem[memAddr[7:0]]};

  always @(posedge clk) begin
    if (memWe[0]) mem[memAddr[7:0]] <= memWrData[7:0];
    if (memWe[1]) mem[8'(memAddr[7:0] + 8'd1)] <= memWrData[15:8];
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares port read data against queued expectations.
  always @(negedge clk) begin
    if (portRd && expVal.size() > 0) begin
      logic [15:0] e;
      string r;
      e = expVal.pop_front();
      r = expReq.pop_front();
      chk(r, portRdData, e);
    end
  end

  task automatic regWrite(logic [3:0] a, logic [7:0] d);
    @(posedge clk); #1;
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic regRead(logic [3:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    regAddr = a;
    @(negedge clk);
    d = regRdData;
  endtask

  task automatic chkReg(string req, logic [3:0] a, logic [7:0] exp);
    logic [7:0] v;
    regRead(a, v);
    chk(req, {8'h0, v}, {8'h0, exp});
  endtask

  // Driver: queues the expected value when the read is meant to be accepted.
  task automatic portRead(bit expectIt, string req, logic [15:0] exp);
    @(posedge clk); #1;
    if (expectIt) begin expVal.push_back(exp); expReq.push_back(req); end
    portRd = 1'b1;
    @(posedge clk); #1;
    portRd = 1'b0;
  endtask

  task automatic portWrite(logic [15:0] d);
    @(posedge clk); #1;
    portWr = 1'b1; portWrData = d;
    @(posedge clk); #1;
    portWr = 1'b0;
  endtask

  task automatic setup(logic [15:0] sa, logic [15:0] cnt);
    regWrite(4'd1, sa[7:0]);  regWrite(4'd2, sa[15:8]);
    regWrite(4'd3, cnt[7:0]); regWrite(4'd4, cnt[15:8]);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", {15'b0, rdmaDone}, 16'h0);
    chk("R1 we", {14'b0, memWe}, 16'h0);
    chkReg("R1 cur", 4'd5, 8'h00);
    chkReg("R1 rem", 4'd9, 8'h00);
    chkReg("R1 stat", 4'd7, 8'h00);

    // R2/R3/R5 byte read run of three
    setup(16'h0010, 16'd3);
    regWrite(4'd0, 8'h08);
    chkReg("R2 cur lo", 4'd5, 8'h10);
    chkReg("R2 cur hi", 4'd6, 8'h00);
    chkReg("R2 rem", 4'd9, 8'h03);
    portRead(1, "R3 read0", {8'h0, refVal(16'h10)});
    portRead(1, "R3 read1", {8'h0, refVal(16'h11)});
    chkReg("R3 cur step", 4'd5, 8'h12);
    chkReg("R3 rem step", 4'd9, 8'h01);
    chk("R5 not yet", {15'b0, rdmaDone}, 16'h0);
    portRead(1, "R3 read2", {8'h0, refVal(16'h12)});
    chk("R5 done pin", {15'b0, rdmaDone}, 16'h1);
    chkReg("R5 stat", 4'd7, 8'h40);
    portRead(0, "", 16'h0);
    chkReg("R7 read after end", 4'd5, 8'h13);

    // R6 sticky flag
    regWrite(4'd7, 8'h00);
    chk("R6 stays", {15'b0, rdmaDone}, 16'h1);
    regWrite(4'd7, 8'h40);
    chk("R6 cleared", {15'b0, rdmaDone}, 16'h0);

    // R4/R7 byte write run of two
    setup(16'h0040, 16'd2);
    regWrite(4'd0, 8'h10);
    portRead(0, "", 16'h0);
    chkReg("R7 wrong direction", 4'd5, 8'h40);
    portWrite(16'hA5B6);
    chk("R4 byte0", {8'h0, mem[8'h40]}, 16'h00B6);
    chk("R4 lane1 untouched", {8'h0, mem[8'h41]}, {8'h0, refVal(16'h41)});
    portWrite(16'h77C3);
    chk("R4 byte1", {8'h0, mem[8'h41]}, 16'h00C3);
    chk("R5 write done", {15'b0, rdmaDone}, 16'h1);
    portWrite(16'h1234);
    chk("R7 write after end", {8'h0, mem[8'h42]}, {8'h0, refVal(16'h42)});
    chkReg("R7 cur hold", 4'd5, 8'h42);
    regWrite(4'd7, 8'h40);

    // R9 word read run of four
    regWrite(4'd8, 8'h01);
    setup(16'h0020, 16'd4);
    regWrite(4'd0, 8'h08);
    portRead(1, "R9 word0", {refVal(16'h21), refVal(16'h20)});
    portRead(1, "R9 word1", {refVal(16'h23), refVal(16'h22)});
    chk("R9 word done", {15'b0, rdmaDone}, 16'h1);
    chkReg("R9 word cur", 4'd5, 8'h24);
    regWrite(4'd7, 8'h40);

    // R9 word write with odd count three
    setup(16'h0030, 16'd3);
    regWrite(4'd0, 8'h10);
    portWrite(16'h1122);
    chk("R9 lanes", {mem[8'h31], mem[8'h30]}, 16'h1122);
    chkReg("R9 rem one", 4'd9, 8'h01);
    chk("R9 not done", {15'b0, rdmaDone}, 16'h0);
    portWrite(16'h3344);
    chk("R9 last lanes", {mem[8'h33], mem[8'h32]}, 16'h3344);
    chkReg("R9 rem clamp", 4'd9, 8'h00);
    chkReg("R9 rem clamp hi", 4'd10, 8'h00);
    chk("R9 odd done", {15'b0, rdmaDone}, 16'h1);
    regWrite(4'd7, 8'h40);
    regWrite(4'd8, 8'h00);

    // R8 abort mid-run
    setup(16'h0050, 16'd5);
    regWrite(4'd0, 8'h08);
    portRead(1, "R8 pre-abort", {8'h0, refVal(16'h50)});
    regWrite(4'd0, 8'h20);
    chk("R8 no done", {15'b0, rdmaDone}, 16'h0);
    chkReg("R8 cur kept", 4'd5, 8'h51);
    portRead(0, "", 16'h0);
    chkReg("R8 stopped", 4'd5, 8'h51);

    // R10 zero count
    setup(16'h0060, 16'd0);
    regWrite(4'd0, 8'h08);
    chk("R10 done", {15'b0, rdmaDone}, 16'h1);
    chkReg("R10 cur", 4'd5, 8'h60);
    portRead(0, "", 16'h0);
    chkReg("R10 no move", 4'd5, 8'h60);
    regWrite(4'd7, 8'h40);

    // R11 no-op codes, R12 register writes during a run
    setup(16'h0070, 16'd4);
    regWrite(4'd0, 8'h08);
    portRead(1, "R11 first", {8'h0, refVal(16'h70)});
    regWrite(4'd0, 8'h18);
    regWrite(4'd0, 8'h00);
    regWrite(4'd0, 8'h38);
    chkReg("R11 rem kept", 4'd9, 8'h03);
    portRead(1, "R11 continues", {8'h0, refVal(16'h71)});
    chkReg("R11 cur", 4'd5, 8'h72);
    setup(16'h0099, 16'd9);
    chkReg("R12 cur untouched", 4'd5, 8'h72);
    chkReg("R12 rem untouched", 4'd9, 8'h02);
    chkReg("R12 start stored", 4'd1, 8'h99);
    regWrite(4'd0, 8'h20);

    repeat (2) @(posedge clk);
    if (expVal.size() != 0) begin
      nCmp++; nBad++;
      $display("FAIL R3: actual %0d pending expected 0", expVal.size());
    end
    report();
  end
endmodule